// File: doc/BRIEF.md
# Extended-Resolution Pulse-Width Modulator

This block produces a pulse-width modulated output with 8-bit average resolution. It does not need a full 256-step comparison per period. Instead, a 6-bit base counter sets the basic period of 64 counter ticks. The upper six bits of the duty value set how many ticks at the start of each base period are driven high. A 2-bit extension counter numbers four consecutive base periods as one frame. The two low bits of the duty value pick which of those periods gain one extra high tick. Averaged over a frame, the high time equals the full 8-bit duty value, while the base period stays at 64 ticks.

Software writes a new duty value into a holding register. The generator uses it only at a reload point, so a period never mixes two duty values. The reload point is selectable: the end of each base period, or the end of the full four-period frame. The counter advances on a clock enable from an internal prescaler that divides the system clock by 64, 8, 2 or 1. A run input starts and pauses counting. A one-cycle restart input returns the counter and prescaler to zero. Every frame wrap raises a pending interrupt flag, which stays set until it is acknowledged.

Top module: `xpwm_gen`

## Requirements
- R1: After reset the output is low, the interrupt flag is clear, the counter is at zero and the active duty value is zero. With no duty written, the output stays low while the generator runs.
- R2: Let c be the active duty bits [7:2], b the base count (counter bits [5:0]) and p the period index (counter bits [7:6]). In every base period with c nonzero, the output is high while b < c and low from b = c up to the base wrap. It goes high again when b returns to 0.
- R3: When c is zero, the output stays low for the whole of every base period that is not stretched.
- R4: Let f be duty bits [1:0]. A stretched period is also high at b = c. For f = 1 only period 1 is stretched. For f = 2, periods 1 and 3 are stretched. For f = 3, periods 1, 2 and 3 are stretched. For f = 0, no period is stretched. Over one frame of 256 ticks, the number of high ticks equals the 8-bit duty value.
- R5: With `reload_short` = 0, a value written to `data_in` takes effect only at the tick on which the counter wraps from 255 to 0.
- R6: With `reload_short` = 1, a written value takes effect at the next tick on which the base count wraps from 63 to 0.
- R7: A cycle with `cnt_clr` high sets the counter and prescaler to zero and loads the held duty value at once. Counting then resumes from tick 0 with no further action.
- R8: While `run_en` is 0, the counter and prescaler hold their values and the output holds its level. Setting `run_en` to 1 again continues the sequence from where it stopped.
- R9: `psc_sel` sets the tick rate: 00 gives one tick per 64 clocks, 01 one per 8, 10 one per 2, and 11 one per clock. After a restart, the first tick comes on the divisor-th enabled clock.
- R10: `irq_pend` is set on the tick that wraps the counter from 255 to 0. It stays set until a cycle with `irq_ack` high, which clears it unless a wrap occurs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 = count, 0 = hold |
| cnt_clr | input | 1 | One-cycle pulse that restarts counter and prescaler |
| reload_short | input | 1 | 1 = reload duty at base wrap, 0 = at frame wrap |
| psc_sel | input | 2 | Tick divisor select (00 /64, 01 /8, 10 /2, 11 /1) |
| data_wr | input | 1 | Write strobe for the duty holding register |
| data_in | input | 8 | Duty value: [7:2] base duty, [1:0] stretch count |
| irq_ack | input | 1 | Clears the pending interrupt flag |
| pwm_out | output | 1 | Modulated output |
| irq_pend | output | 1 | Frame-wrap interrupt pending flag |

## Verification
On every cycle, the assertions check the following:
- the counter either holds or steps by exactly one, depending on the tick and the restart;
- the active duty value changes only at a restart or a wrap, and not at a base wrap in frame-reload mode;
- the high phase begins only at base count zero;
- the divide-by-one setting ticks on every running clock;
- a frame wrap always leaves the interrupt flag set.

Some behaviours can only be shown by the bench's scenarios. These are the exact high widths and the stretch pattern across a frame, the 256-tick sum equal to the duty value, the period at which a mid-frame write takes effect, and the tick rates of the slower divisors.

// File: rtl/xpwm_pkg.sv
package xpwm_pkg;
   // tick divisor select codes
   typedef enum logic [1:0] {
      PSC_DIV64 = 2'b00,
      PSC_DIV8  = 2'b01,
      PSC_DIV2  = 2'b10,
      PSC_DIV1  = 2'b11
   } psc_sel_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/xpwm_prescaler.sv
module xpwm_prescaler
   import xpwm_pkg::*;
#(
   parameter int LOG_DIV_A = 6,
   parameter int LOG_DIV_B = 3,
   parameter int LOG_DIV_C = 1,
   parameter int LOG_DIV_D = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int RAW_W = max4(LOG_DIV_A, LOG_DIV_B, LOG_DIV_C, LOG_DIV_D);
   localparam int PSC_W = (RAW_W < 1) ? 1 : RAW_W;
   localparam logic [PSC_W-1:0] MASK_A = PSC_W'((1 << LOG_DIV_A) - 1);
   localparam logic [PSC_W-1:0] MASK_B = PSC_W'((1 << LOG_DIV_B) - 1);
   localparam logic [PSC_W-1:0] MASK_C = PSC_W'((1 << LOG_DIV_C) - 1);
   localparam logic [PSC_W-1:0] MASK_D = PSC_W'((1 << LOG_DIV_D) - 1);

   if (LOG_DIV_A < 0 || LOG_DIV_B < 0 || LOG_DIV_C < 0 || LOG_DIV_D < 0) begin : g_bad_div
      $error("xpwm_prescaler: divisor logs must be non-negative");
   end

   logic [PSC_W-1:0] pcnt;
   logic [PSC_W-1:0] mask;

   always_comb begin
      case (psc_sel_e'(sel))
         PSC_DIV64: mask = MASK_A;
         PSC_DIV8:  mask = MASK_B;
         PSC_DIV2:  mask = MASK_C;
         default:   mask = MASK_D;
      endcase
   end

   assign tick = run && !restart && ((pcnt & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else if (run)     pcnt <= pcnt + 1'b1;
   end

   // R9
   div1_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && sel == 2'b11) |-> tick);

   // R8
   psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(pcnt));
endmodule

// File: rtl/xpwm_counter.sv
module xpwm_counter #(
   parameter int BASE_W = 6,
   parameter int EXT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              restart,
   output logic [BASE_W-1:0] base,
   output logic [EXT_W-1:0]  ext,
   output logic              wrap_base,
   output logic              wrap_full
);
   localparam int CNT_W = BASE_W + EXT_W;

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tick)    cnt <= cnt + 1'b1;
   end

   assign base      = cnt[BASE_W-1:0];
   assign ext       = cnt[CNT_W-1:BASE_W];
   assign wrap_base = tick && !restart && (&cnt[BASE_W-1:0]);
   assign wrap_full = tick && !restart && (&cnt);

   // R8
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(cnt));

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart) |=> (cnt == $past(cnt) + 1'b1));

   // R7
   cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));
endmodule

// File: rtl/xpwm_wave.sv
module xpwm_wave #(
   parameter int BASE_W  = 6,
   parameter int EXT_W   = 2,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     data_wr,
   input  logic [BASE_W+EXT_W-1:0]  data_in,
   input  logic                     reload_short,
   input  logic                     restart,
   input  logic                     wrap_base,
   input  logic                     wrap_full,
   input  logic [BASE_W-1:0]        base,
   input  logic [EXT_W-1:0]         ext,
   output logic                     pwm
);
   localparam int DATA_W = BASE_W + EXT_W;
   localparam logic [EXT_W-1:0] ONE_E = EXT_W'(1);

   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] act_q;
   logic              reload;
   logic [BASE_W-1:0] coarse;
   logic [EXT_W-1:0]  fine;
   logic [EXT_W-1:0]  prev_idx;
   logic [EXT_W-1:0]  rank;
   logic              stretch;
   logic              hi_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= '0;
      else if (data_wr) hold_q <= data_in;
   end

   assign reload = restart || (reload_short ? wrap_base : wrap_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q <= '0;
      else if (reload) act_q <= hold_q;
   end

   assign coarse   = act_q[DATA_W-1:EXT_W];
   assign fine     = act_q[EXT_W-1:0];
   assign prev_idx = ext - ONE_E;

   // stretch order: bit-reversed position of (period - 1)
   always_comb begin
      for (int i = 0; i < EXT_W; i++) rank[i] = prev_idx[EXT_W-1-i];
   end

   assign stretch = (rank < fine);
   assign hi_c    = (base < coarse) || ((base == coarse) && stretch);

   if (REG_OUT) begin : g_reg_out
      logic pwm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_q <= 1'b0;
         else        pwm_q <= hi_c;
      end
      assign pwm = pwm_q;
   end else begin : g_comb_out
      assign pwm = hi_c;
   end

   // R5
   long_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_short && wrap_base && !wrap_full && !restart) |=> $stable(act_q));

   // R6
   no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !wrap_base && !wrap_full) |=> $stable(act_q));

   // R2
   rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_c) |-> (base == '0));
endmodule

// File: rtl/xpwm_gen.sv
module xpwm_gen #(
   parameter int BASE_W    = 6,
   parameter int EXT_W     = 2,
   parameter int LOG_DIV_A = 6,
   parameter int LOG_DIV_B = 3,
   parameter int LOG_DIV_C = 1,
   parameter int LOG_DIV_D = 0,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run_en,
   input  logic                    cnt_clr,
   input  logic                    reload_short,
   input  logic [1:0]              psc_sel,
   input  logic                    data_wr,
   input  logic [BASE_W+EXT_W-1:0] data_in,
   input  logic                    irq_ack,
   output logic                    pwm_out,
   output logic                    irq_pend
);
   if (BASE_W < 2 || BASE_W > 16) begin : g_bad_base
      $error("xpwm_gen: BASE_W out of range");
   end
   if (EXT_W < 1 || EXT_W > 4) begin : g_bad_ext
      $error("xpwm_gen: EXT_W out of range");
   end

   logic              tick;
   logic [BASE_W-1:0] base;
   logic [EXT_W-1:0]  ext;
   logic              wrap_base;
   logic              wrap_full;
   logic              irq_q;

   xpwm_prescaler #(
      .LOG_DIV_A(LOG_DIV_A), .LOG_DIV_B(LOG_DIV_B),
      .LOG_DIV_C(LOG_DIV_C), .LOG_DIV_D(LOG_DIV_D)
   ) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run_en), .restart(cnt_clr),
      .sel(psc_sel), .tick(tick)
   );

   xpwm_counter #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(cnt_clr),
      .base(base), .ext(ext), .wrap_base(wrap_base), .wrap_full(wrap_full)
   );

   xpwm_wave #(.BASE_W(BASE_W), .EXT_W(EXT_W), .REG_OUT(REG_OUT)) u_wave (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
      .reload_short(reload_short), .restart(cnt_clr),
      .wrap_base(wrap_base), .wrap_full(wrap_full),
      .base(base), .ext(ext), .pwm(pwm_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (wrap_full) irq_q <= 1'b1;
      else if (irq_ack)   irq_q <= 1'b0;
   end
   assign irq_pend = irq_q;

   // R10
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_full |=> irq_pend);

   // R10
   irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !irq_ack) |=> irq_pend);
endmodule

// File: tb/sim_xpwm_gen.sv
`timescale 1ns/1ps
module sim_xpwm_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0;
   logic       cnt_clr = 1'b0;
   logic       reload_short = 1'b0;
   logic [1:0] psc_sel = 2'b11;
   logic       data_wr = 1'b0;
   logic [7:0] data_in = 8'h00;
   logic       irq_ack = 1'b0;
   logic       pwm_out;
   logic       irq_pend;

   int errs = 0;
   int checks = 0;
   int t = 0;
   int div = 1;
   int dat_a = 0;
   int dat_b = 0;
   int sw_k = 1 << 30;
   int hi_cnt = 0;
   bit done = 0;

   always #10 clk = ~clk;

   xpwm_gen u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_clr(cnt_clr),
      .reload_short(reload_short), .psc_sel(psc_sel), .data_wr(data_wr),
      .data_in(data_in), .irq_ack(irq_ack), .pwm_out(pwm_out), .irq_pend(irq_pend)
   );

   // data value, expected high ticks over one 256-tick frame (R4)
   localparam logic [16:0] VEC [0:10] = '{
      {8'h00, 9'd0},   {8'h01, 9'd1},   {8'h02, 9'd2},   {8'h03, 9'd3},
      {8'h04, 9'd4},   {8'h05, 9'd5},   {8'h06, 9'd6},   {8'h07, 9'd7},
      {8'h42, 9'd66},  {8'h80, 9'd128}, {8'hFF, 9'd255}
   };

   function automatic bit exp_pwm(input int k, input int da, input int db, input int swk);
      int d, c, f, b, p;
      bit st;
      d = (k >= swk) ? db : da;
      c = d >> 2;
      f = d & 3;
      b = k % 64;
      p = (k / 64) % 4;
      st = (f == 1 && p == 1) || (f == 2 && (p == 1 || p == 3)) || (f == 3 && p != 0);
      return (b < c) || (b == c && st);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      if (run_en) t++;
   endtask

   // compare pwm_out against the model for n cycles; one check per call
   task automatic run(input int n, input string req);
      int bad = 0;
      int fa = 0, fe = 0;
      for (int i = 0; i < n; i++) begin
         bit e;
         e = exp_pwm(t / div, dat_a, dat_b, sw_k);
         if (pwm_out) hi_cnt++;
         if (pwm_out !== e) begin
            if (bad == 0) begin fa = pwm_out; fe = e; end
            bad++;
         end
         step();
      end
      check(bad == 0, req, fa, fe);
   endtask

   task automatic clear_start(input int d, input logic [1:0] sel, input logic shortm, input int dv);
      psc_sel = sel; reload_short = shortm; run_en = 1'b1;
      data_wr = 1'b1; data_in = d[7:0]; irq_ack = 1'b1;
      @(posedge clk); #1;
      data_wr = 1'b0; cnt_clr = 1'b1;
      @(posedge clk); #1;
      cnt_clr = 1'b0; irq_ack = 1'b0;
      t = 0; div = dv; dat_a = d; dat_b = d; sw_k = 1 << 30; hi_cnt = 0;
   endtask

   task automatic write_mid(input int d);
      data_wr = 1'b1; data_in = d[7:0];
      run(1, "R5/R6 write cycle");
      data_wr = 1'b0;
   endtask

   initial begin
      // R1: reset state
      #5;
      check(pwm_out === 1'b0, "R1 pwm low in reset", pwm_out, 0);
      check(irq_pend === 1'b0, "R1 irq clear in reset", irq_pend, 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      run_en = 1'b1; psc_sel = 2'b11;
      t = 0; div = 1; dat_a = 0; dat_b = 0;
      run(300, "R1 idle output low with zero duty");

      // R2 R3 R4: vector table at divide-by-one, frame reload
      for (int v = 0; v < 11; v++) begin
         clear_start(int'(VEC[v][16:9]), 2'b11, 1'b0, 1);
         run(256, "R2/R3/R4 per-tick waveform");
         check(hi_cnt == int'(VEC[v][8:0]), "R4 frame high count", hi_cnt, int'(VEC[v][8:0]));
      end

      // R5: frame reload point
      clear_start(8'h80, 2'b11, 1'b0, 1);
      run(100, "R5 before write");
      dat_b = 8'h21; sw_k = 256;
      write_mid(8'h21);
      run(411, "R5 switch at frame wrap");

      // R6: base-period reload point
      clear_start(8'h80, 2'b11, 1'b1, 1);
      run(100, "R6 before write");
      dat_b = 8'h16; sw_k = 128;
      write_mid(8'h16);
      run(200, "R6 switch at base wrap");

      // R7: restart mid-period
      clear_start(8'h44, 2'b11, 1'b0, 1);
      run(70, "R7 first pass");
      clear_start(8'h44, 2'b11, 1'b0, 1);
      run(70, "R7 restart from tick zero");

      // R8: pause and resume
      clear_start(8'h80, 2'b11, 1'b0, 1);
      run(10, "R8 before pause");
      run_en = 1'b0;
      run(20, "R8 output holds while paused");
      run_en = 1'b1;
      run(120, "R8 sequence resumes");

      // R9: divisors
      clear_start(8'h10, 2'b01, 1'b0, 8);
      run(600, "R9 divide by 8");
      clear_start(8'h0A, 2'b10, 1'b0, 2);
      run(300, "R9 divide by 2");
      clear_start(8'h11, 2'b00, 1'b0, 64);
      run(64 * 80, "R9 divide by 64");

      // R10: interrupt flag
      clear_start(8'h40, 2'b11, 1'b0, 1);
      run(255, "R10 lead-in");
      check(irq_pend === 1'b0, "R10 clear before wrap", irq_pend, 0);
      run(1, "R10 wrap tick");
      check(irq_pend === 1'b1, "R10 set at wrap", irq_pend, 1);
      run(10, "R10 hold");
      check(irq_pend === 1'b1, "R10 held until ack", irq_pend, 1);
      irq_ack = 1'b1;
      step();
      irq_ack = 1'b0;
      check(irq_pend === 1'b0, "R10 cleared by ack", irq_pend, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(20.0 * 150000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule